// File: doc/BRIEF.md
# RS-485 Direction Control and Station Address Filter

This block sits beside one UART channel on a shared half-duplex RS-485 bus. On the transmit side it owns the external line driver enable. When automatic direction control is on, the enable goes active as soon as the transmitter reports a start. It stays active for the whole frame. After the transmitter reports that the last stop bit has left the shift register, the enable is held for a programmable number of bit times and then released. Either the RTS output or the DTR output can carry this enable. The output that is not selected keeps its normal source.

On the receive side, 9-bit addressing can be turned on. The ninth received bit then marks a frame as an address frame. The block compares each address frame with the programmed station address. It forwards a frame to the receive FIFO write port only when that frame belongs to this node. Baud generation and framing are outside the block. It only sees the transmitter start and done strobes, a one-cycle bit-time tick, and received bytes with their ninth bit.

Top module: `rs485_dir_filter`

## Requirements
- R1: After reset the direction logic is idle, so the driver enable is inactive, and `fifo_wr` is low.
- R2: With `cfg_auto_dir` low, `rts_o` equals `rts_reg` when `flow_en` is 0 and equals `rts_flow` when `flow_en` is 1. `dtr_o` equals `dtr_reg`.
- R3: With `cfg_auto_dir` high and `cfg_use_dtr` low, a `tx_start` pulse drives `rts_o` high from the next cycle. This overrides both `rts_reg` and `rts_flow`.
- R4: With `cfg_auto_dir` high and `cfg_use_dtr` high, the driver enable appears on `dtr_o`. `rts_o` keeps its R2 source.
- R5: After `tx_done`, the enable stays high until the N-th `bit_tick`, where N = `cfg_turn` (8 bits). It drops in the cycle after that tick. Ticks that arrive while a frame is still being sent do not count.
- R6: With `cfg_turn` = 0, the enable drops in the cycle after `tx_done`.
- R7: A `tx_start` during the hold countdown cancels the countdown and keeps the enable high. A fresh `tx_done` then starts a full countdown.
- R8: With `cfg_addr_en` high and the node not addressed, received data frames (`rx_addr_bit` = 0) do not cause a FIFO write.
- R9: A received address frame (`rx_addr_bit` = 1) equal to `cfg_station` sets the addressed state. That byte is written: `fifo_wr` = 1 with `fifo_data` equal to it, one cycle after `rx_valid`. Later data frames are written in the same way.
- R10: An address frame that does not match is not written, and it clears the addressed state, so the data frames after it are dropped.
- R11: With `cfg_addr_en` low, every received frame is written one cycle after `rx_valid`, whatever its ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_auto_dir | input | 1 | Automatic driver-enable control on |
| cfg_use_dtr | input | 1 | 1: enable on DTR output, 0: on RTS output |
| cfg_turn | input | 8 | Hold time after last stop bit, in bit times |
| cfg_addr_en | input | 1 | 9-bit address filtering on |
| cfg_station | input | 8 | Station address of this node |
| rts_reg | input | 1 | Register-driven RTS value |
| flow_en | input | 1 | Hardware flow control drives RTS |
| rts_flow | input | 1 | RTS value from flow control logic |
| dtr_reg | input | 1 | Register-driven DTR value |
| tx_start | input | 1 | Transmitter begins a frame (one-cycle pulse) |
| tx_done | input | 1 | Last stop bit shifted out (one-cycle pulse) |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| rx_valid | input | 1 | Received frame available (one-cycle pulse) |
| rx_data | input | 8 | Received byte |
| rx_addr_bit | input | 1 | Ninth bit: 1 marks an address frame |
| rts_o | output | 1 | RTS pin value |
| dtr_o | output | 1 | DTR pin value |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Byte to write into the receive FIFO |

## Verification
The properties assume that the configuration inputs stay constant for the cycle after any strobe they are checked against. They also assume `tx_start`, `tx_done`, `bit_tick` and `rx_valid` are single-cycle pulses. The stimulus changes configuration only between transactions, at falling edges, with no strobe pending. Every strobe is raised for exactly one cycle. `tx_done` is only issued after a matching `tx_start`.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_TX   = 2'd1,
        DIR_HOLD = 2'd2
    } dir_state_e;

    localparam int PIN_RTS = 0;
    localparam int PIN_DTR = 1;
    localparam int NUM_PINS = 2;
endpackage

// File: rtl/rs485_turnaround.sv
module rs485_turnaround
    import rs485_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic             tx_done,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] turn_bits,
    output logic             dir_active
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        dir_state_e       state;
        logic [CNT_W-1:0] cnt;
    } turn_regs_t;

    turn_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            DIR_IDLE: begin
                if (tx_start) r_d.state = DIR_TX;
            end
            DIR_TX: begin
                if (!tx_start && tx_done) begin
                    if (turn_bits == '0) begin
                        r_d.state = DIR_IDLE;
                    end else begin
                        r_d.state = DIR_HOLD;
                        r_d.cnt   = turn_bits;
                    end
                end
            end
            DIR_HOLD: begin
                if (tx_start) begin
                    r_d.state = DIR_TX;
                    r_d.cnt   = '0;
                end else if (bit_tick) begin
                    if (r_q.cnt == CNT_ONE) begin
                        r_d.state = DIR_IDLE;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt - CNT_ONE;
                    end
                end
            end
            default: begin
                r_d.state = DIR_IDLE;
                r_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= DIR_IDLE;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dir_active = (r_q.state != DIR_IDLE);
endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux
    import rs485_pkg::*;
(
    input  logic auto_dir,
    input  logic use_dtr,
    input  logic dir_active,
    input  logic rts_reg,
    input  logic flow_en,
    input  logic rts_flow,
    input  logic dtr_reg,
    output logic rts_o,
    output logic dtr_o
);
    logic [NUM_PINS-1:0] normal_src;
    logic [NUM_PINS-1:0] pin_val;
    logic [NUM_PINS-1:0] pin_sel;

    always_comb begin
        normal_src          = '0;
        normal_src[PIN_RTS] = flow_en ? rts_flow : rts_reg;
        normal_src[PIN_DTR] = dtr_reg;
        pin_sel             = '0;
        pin_sel[PIN_RTS]    = auto_dir && !use_dtr;
        pin_sel[PIN_DTR]    = auto_dir && use_dtr;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign pin_val[g] = pin_sel[g] ? dir_active : normal_src[g];
    end

    assign rts_o = pin_val[PIN_RTS];
    assign dtr_o = pin_val[PIN_DTR];
endmodule

// File: rtl/rs485_addr_filter.sv
module rs485_addr_filter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_en,
    input  logic [DATA_W-1:0] station,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_addr_bit,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data
);
    typedef struct packed {
        logic              addressed;
        logic              wr;
        logic [DATA_W-1:0] data;
    } filt_regs_t;

    filt_regs_t f_q, f_d;
    logic       addr_match;

    assign addr_match = (rx_data == station);

    always_comb begin
        f_d    = f_q;
        f_d.wr = 1'b0;
        if (!addr_en) f_d.addressed = 1'b0;
        if (rx_valid) begin
            if (!addr_en) begin
                f_d.wr   = 1'b1;
                f_d.data = rx_data;
            end else if (rx_addr_bit) begin
                f_d.addressed = addr_match;
                if (addr_match) begin
                    f_d.wr   = 1'b1;
                    f_d.data = rx_data;
                end
            end else if (f_q.addressed) begin
                f_d.wr   = 1'b1;
                f_d.data = rx_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.addressed <= 1'b0;
            f_q.wr        <= 1'b0;
            f_q.data      <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign fifo_wr   = f_q.wr;
    assign fifo_data = f_q.data;
endmodule

// File: rtl/rs485_dir_filter.sv
module rs485_dir_filter #(
    parameter int TURN_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_auto_dir,
    input  logic              cfg_use_dtr,
    input  logic [TURN_W-1:0] cfg_turn,
    input  logic              cfg_addr_en,
    input  logic [DATA_W-1:0] cfg_station,
    input  logic              rts_reg,
    input  logic              flow_en,
    input  logic              rts_flow,
    input  logic              dtr_reg,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              bit_tick,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_addr_bit,
    output logic              rts_o,
    output logic              dtr_o,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data
);
    logic dir_active;

    rs485_turnaround #(.CNT_W(TURN_W)) u_turn (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_start   (tx_start),
        .tx_done    (tx_done),
        .bit_tick   (bit_tick),
        .turn_bits  (cfg_turn),
        .dir_active (dir_active)
    );

    rs485_pin_mux u_mux (
        .auto_dir   (cfg_auto_dir),
        .use_dtr    (cfg_use_dtr),
        .dir_active (dir_active),
        .rts_reg    (rts_reg),
        .flow_en    (flow_en),
        .rts_flow   (rts_flow),
        .dtr_reg    (dtr_reg),
        .rts_o      (rts_o),
        .dtr_o      (dtr_o)
    );

    rs485_addr_filter #(.DATA_W(DATA_W)) u_filt (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_en     (cfg_addr_en),
        .station     (cfg_station),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_addr_bit (rx_addr_bit),
        .fifo_wr     (fifo_wr),
        .fifo_data   (fifo_data)
    );
endmodule

// File: rtl/rs485_dir_filter_chk.sv
module rs485_dir_filter_chk #(
    parameter int TURN_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_auto_dir,
    input logic              cfg_use_dtr,
    input logic [TURN_W-1:0] cfg_turn,
    input logic              cfg_addr_en,
    input logic [DATA_W-1:0] cfg_station,
    input logic              tx_start,
    input logic              tx_done,
    input logic              bit_tick,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_addr_bit,
    input logic              rts_o,
    input logic              dtr_o,
    input logic              fifo_wr,
    input logic [DATA_W-1:0] fifo_data,
    input logic              dir_active
);
    AST_RTS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_dir && !cfg_use_dtr && tx_start) |=> rts_o); // R3
    AST_DTR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_dir && cfg_use_dtr && tx_start) |=> dtr_o); // R4
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_active && !bit_tick && !tx_done) |=> dir_active); // R5
    AST_ZERO_TURN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_active && tx_done && !tx_start && cfg_turn == '0) |=> !dir_active); // R6
    AST_RESTART_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_active && tx_start) |=> dir_active); // R7
    AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !fifo_wr); // R8
    AST_MATCH_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_addr_en && rx_addr_bit && rx_data == cfg_station)
        |=> (fifo_wr && fifo_data == $past(rx_data))); // R9
    AST_FOREIGN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_addr_en && rx_addr_bit && rx_data != cfg_station) |=> !fifo_wr); // R10
    AST_PASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_addr_en) |=> (fifo_wr && fifo_data == $past(rx_data))); // R11
endmodule

bind rs485_dir_filter rs485_dir_filter_chk #(.TURN_W(TURN_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_auto_dir (cfg_auto_dir),
    .cfg_use_dtr  (cfg_use_dtr),
    .cfg_turn     (cfg_turn),
    .cfg_addr_en  (cfg_addr_en),
    .cfg_station  (cfg_station),
    .tx_start     (tx_start),
    .tx_done      (tx_done),
    .bit_tick     (bit_tick),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_addr_bit  (rx_addr_bit),
    .rts_o        (rts_o),
    .dtr_o        (dtr_o),
    .fifo_wr      (fifo_wr),
    .fifo_data    (fifo_data),
    .dir_active   (dir_active)
);

// File: tb/rs485_dir_filter_test.sv
`timescale 1ns/1ps
module rs485_dir_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_auto_dir = 1'b0, cfg_use_dtr = 1'b0, cfg_addr_en = 1'b0;
    logic [7:0] cfg_turn = 8'd0, cfg_station = 8'h5A;
    logic       rts_reg = 1'b0, flow_en = 1'b0, rts_flow = 1'b0, dtr_reg = 1'b0;
    logic       tx_start = 1'b0, tx_done = 1'b0, bit_tick = 1'b0;
    logic       rx_valid = 1'b0, rx_addr_bit = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rts_o, dtr_o, fifo_wr;
    logic [7:0] fifo_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    rs485_dir_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_auto_dir(cfg_auto_dir), .cfg_use_dtr(cfg_use_dtr),
        .cfg_turn(cfg_turn), .cfg_addr_en(cfg_addr_en), .cfg_station(cfg_station),
        .rts_reg(rts_reg), .flow_en(flow_en), .rts_flow(rts_flow), .dtr_reg(dtr_reg),
        .tx_start(tx_start), .tx_done(tx_done), .bit_tick(bit_tick),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_addr_bit(rx_addr_bit),
        .rts_o(rts_o), .dtr_o(dtr_o), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
    );

    // Entry: {addr_en, addr_bit, byte, expect_write, expect_byte}; station 0x5A
    localparam int NV = 11;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h11, 1'b0, 8'h00},  // R8 data while unaddressed
        {1'b1, 1'b1, 8'h33, 1'b0, 8'h00},  // R10 foreign address
        {1'b1, 1'b1, 8'h5A, 1'b1, 8'h5A},  // R9 own address written
        {1'b1, 1'b0, 8'h22, 1'b1, 8'h22},  // R9 data passed
        {1'b1, 1'b0, 8'h23, 1'b1, 8'h23},  // R9
        {1'b1, 1'b1, 8'h40, 1'b0, 8'h00},  // R10 other address clears
        {1'b1, 1'b0, 8'h24, 1'b0, 8'h00},  // R10 data dropped
        {1'b1, 1'b1, 8'h5A, 1'b1, 8'h5A},  // R9 re-addressed
        {1'b1, 1'b0, 8'h77, 1'b1, 8'h77},  // R9
        {1'b0, 1'b0, 8'h99, 1'b1, 8'h99},  // R11 filtering off
        {1'b0, 1'b1, 8'h12, 1'b1, 8'h12}   // R11 ninth bit ignored
    };

    task automatic chk1(string req, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start();
        tx_start = 1'b1; step(); tx_start = 1'b0;
    endtask
    task automatic pulse_done();
        tx_done = 1'b1; step(); tx_done = 1'b0;
    endtask
    task automatic pulse_tick();
        bit_tick = 1'b1; step(); bit_tick = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done_flag) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cfg_auto_dir = 1'b1;
        chk1("R1 rts idle", rts_o, 1'b0);
        chk1("R1 no write", fifo_wr, 1'b0);
        rst_n = 1'b1;
        step();

        // Receive filter vectors
        for (int i = 0; i < NV; i++) begin
            cfg_addr_en = VEC[i][18];
            rx_addr_bit = VEC[i][17];
            rx_data     = VEC[i][16:9];
            rx_valid    = 1'b1;
            step();
            rx_valid = 1'b0;
            chk1($sformatf("R8-11 vec%0d wr", i), fifo_wr, VEC[i][8]);
            if (VEC[i][8]) chk8($sformatf("R9/R11 vec%0d data", i), fifo_data, VEC[i][7:0]);
        end
        cfg_addr_en = 1'b0;

        // R2 normal sources
        cfg_auto_dir = 1'b0;
        rts_reg = 1'b1; dtr_reg = 1'b1; #1;
        chk1("R2 rts from reg", rts_o, 1'b1);
        chk1("R2 dtr from reg", dtr_o, 1'b1);
        flow_en = 1'b1; rts_flow = 1'b0; #1;
        chk1("R2 rts from flow", rts_o, 1'b0);
        rts_flow = 1'b1; #1;
        chk1("R2 rts from flow high", rts_o, 1'b1);
        flow_en = 1'b0; rts_reg = 1'b0; dtr_reg = 1'b0; rts_flow = 1'b0;
        step();

        // R3 / R5 countdown of 3
        cfg_auto_dir = 1'b1; cfg_use_dtr = 1'b0; cfg_turn = 8'd3;
        flow_en = 1'b1; rts_flow = 1'b0;
        pulse_start();
        chk1("R3 rts on start", rts_o, 1'b1);
        pulse_tick(); pulse_tick(); pulse_tick(); pulse_tick();
        chk1("R5 ticks during frame ignored", rts_o, 1'b1);
        pulse_done();
        chk1("R5 hold after done", rts_o, 1'b1);
        pulse_tick();
        chk1("R5 after tick 1", rts_o, 1'b1);
        pulse_tick();
        chk1("R5 after tick 2", rts_o, 1'b1);
        pulse_tick();
        chk1("R5 released after tick 3", rts_o, 1'b0);
        flow_en = 1'b0;

        // R6 zero turnaround
        cfg_turn = 8'd0;
        pulse_start();
        chk1("R6 active", rts_o, 1'b1);
        pulse_done();
        chk1("R6 released at done", rts_o, 1'b0);

        // R7 restart during countdown
        cfg_turn = 8'd2;
        pulse_start();
        pulse_done();
        pulse_tick();
        pulse_start();
        pulse_tick(); pulse_tick(); pulse_tick();
        chk1("R7 countdown cancelled", rts_o, 1'b1);
        pulse_done();
        pulse_tick();
        chk1("R7 fresh count tick 1", rts_o, 1'b1);
        pulse_tick();
        chk1("R7 released after fresh count", rts_o, 1'b0);

        // R4 DTR carries enable
        cfg_use_dtr = 1'b1; cfg_turn = 8'd1; rts_reg = 1'b1;
        step();
        pulse_start();
        chk1("R4 dtr active", dtr_o, 1'b1);
        chk1("R4 rts from reg", rts_o, 1'b1);
        rts_reg = 1'b0; #1;
        chk1("R4 rts follows reg low", rts_o, 1'b0);
        pulse_done();
        pulse_tick();
        chk1("R4 dtr released", dtr_o, 1'b0);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule